// File: doc/BRIEF.md
# Flywheel Receive Bit-Clock Recovery

This block recovers a bit-rate clock from a hard-limited, already demodulated receive bit stream. A digital phase-locked loop divides each bit into sixteen phase slots. It keeps stepping through those slots at the nominal rate even when the data has no transitions. Each qualified data transition nudges the loop by at most one slot per bit, either forward or back, toward the point where the bit boundary should fall.

The loop drives a square-wave sync output. It also latches the synchronised data bit in mid-bit, which gives a clocked data output, and it passes the raw demodulated level straight through as an unclocked output. The bit rate comes from a clock-range select and two baud selects, in the same pin combinations the matching transmitter uses. An external carrier-qualify level gates the phase corrections so that noise edges cannot drag the loop. An active-high receive enable puts the block into powersave.

Top module: `fwclk_recover`

## Requirements
- R1: `data_raw` equals `rx_bit` in the same cycle, at all times.
- R2: The slot timer divides `clk` by D per phase slot, and a bit lasts 16 slots. With base divide B (parameter `BASE_DIV`, a multiple of 4): if `clk_fast_sel`=0, then D=B when `rate_low_sel`=1 and D=B/2 when `rate_low_sel`=0, and `rate_top_sel` is ignored. If `clk_fast_sel`=1, then D=4B when `rate_low_sel`=1, D=2B when `rate_low_sel`=0 and `rate_top_sel`=0, and D=B when `rate_low_sel`=0 and `rate_top_sel`=1.
- R3: With no correction pending, the phase steps by one slot (modulo 16) on each slot tick and holds between ticks. `sync_out` is 1 in slots 0 to 7 and 0 in slots 8 to 15, and it keeps running when the input has no transitions.
- R4: `rx_bit` passes through a two-flop synchroniser. A change on `rx_bit` before clock edge k produces exactly one edge event, which is acted on at edge k+2.
- R5: A qualified edge event seen in slot 1 to 7 requests a retard, so the next tick holds the phase. One seen in slot 8 to 15 requests an advance, so the next tick moves the phase by two. One seen in slot 0 requests nothing.
- R6: Only one correction is taken per bit. While a request is pending, or once one has been applied, further edges are ignored until the phase wraps past slot 15.
- R7: While `carrier_in` is 0, edge events request no correction.
- R8: `data_clocked` takes the synchronised input level on the tick that moves the phase from below slot 8 to slot 8 or above. It holds its value on every other cycle.
- R9: While `rx_en` is 0, `sync_out`, `data_clocked` and `carrier_out` read 0, and the phase, slot timer and synchroniser are cleared, so the loop restarts in slot 0. While `rx_en` is 1, `carrier_out` equals `carrier_in`.
- R10: With `carrier_in`=1 and an alternating preamble at bit periods from 97% to 104% of nominal, each sample taken from the 17th bit on falls in the middle half of its bit and returns that bit's value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (crystal-derived) |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receive enable, 0 = powersave |
| clk_fast_sel | input | 1 | 1 = four-times clock range |
| rate_low_sel | input | 1 | 1 = lowest baud rate |
| rate_top_sel | input | 1 | With fast clock and rate_low_sel=0, selects top rate |
| carrier_in | input | 1 | Carrier qualify level, gates corrections |
| rx_bit | input | 1 | Hard-limited demodulated bit |
| sync_out | output | 1 | Recovered bit-clock square wave |
| data_clocked | output | 1 | Data latched in mid-bit |
| data_raw | output | 1 | Unclocked pass-through of rx_bit |
| carrier_out | output | 1 | Carrier level gated by enable |

## Verification
`data_raw` and `carrier_out` are combinational, so they are due in the same cycle as the input. `sync_out` follows the phase register with no added delay, and an input edge reaches the phase two edges after it was sampled, then waits for the next slot tick. `data_clocked` changes on the same edge that drops `sync_out`. A behavioural model in the bench advances on each rising edge from the same inputs, and both are compared on the falling edge, where all of these delays have settled. Rate periods and lock position are measured separately, by counting cycles between `sync_out` edges and between the bench's own bit boundaries.

// File: rtl/fwclk_pkg.sv
package fwclk_pkg;

  typedef enum logic [1:0] {
    CORR_NONE = 2'd0,
    CORR_ADV  = 2'd1,
    CORR_RET  = 2'd2
  } corr_e;

  // clk cycles per phase slot for a given rate selection
  function automatic int unsigned slot_div(input int unsigned base,
                                           input logic fast,
                                           input logic sel_low,
                                           input logic sel_top);
    int unsigned d;
    d = fast ? base * 4 : base;
    if (!sel_low) begin
      if (fast && sel_top) d = d / 4;
      else                 d = d / 2;
    end
    return d;
  endfunction

  // direction of correction for an edge seen in slot ph
  function automatic corr_e corr_for_slot(input int unsigned ph,
                                          input int unsigned mid);
    if (ph == 0)       return CORR_NONE;
    else if (ph < mid) return CORR_RET;
    else               return CORR_ADV;
  endfunction

  // slots moved on a tick for a given pending correction
  function automatic int unsigned slot_step(input corr_e c);
    case (c)
      CORR_ADV: return 2;
      CORR_RET: return 0;
      default:  return 1;
    endcase
  endfunction

endpackage

// File: rtl/fwclk_sync.sv
module fwclk_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic d_i,
  output logic level_o,
  output logic edge_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else if (!en_i) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign level_o = s2_q;
  assign edge_o  = s2_q ^ s3_q;

  // R9: powersave clears the synchroniser
  a_r9_sync_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!level_o && !edge_o));

endmodule

// File: rtl/fwclk_slot_timer.sv
module fwclk_slot_timer #(
  parameter int unsigned BASE_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic fast_i,
  input  logic sel_low_i,
  input  logic sel_top_i,
  output logic tick_o
);
  import fwclk_pkg::*;

  localparam int unsigned MAX_DIV = BASE_DIV * 4;
  localparam int unsigned CW      = $clog2(MAX_DIV + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] div_m1;

  always_comb begin
    div_m1 = CW'(slot_div(BASE_DIV, fast_i, sel_low_i, sel_top_i) - 1);
  end

  assign tick_o = en_i && (cnt_q >= div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CW'(1);
  end

  // R2: a tick restarts the slot count
  a_r2_tick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (cnt_q == '0));

  // R2: between ticks the count climbs by one
  a_r2_count_climbs: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick_o) |=> (!en_i || cnt_q == $past(cnt_q) + CW'(1)));

endmodule

// File: rtl/fwclk_dpll.sv
module fwclk_dpll #(
  parameter int unsigned SLOTS = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_i,
  input  logic                     tick_i,
  input  logic                     edge_i,
  input  logic                     qual_i,
  output logic [$clog2(SLOTS)-1:0] phase_o,
  output logic                     sample_o
);
  import fwclk_pkg::*;

  localparam int unsigned PW  = $clog2(SLOTS);
  localparam logic [PW-1:0] MID = PW'(SLOTS / 2);

  logic [PW-1:0] phase_q, phase_nx;
  corr_e         req_q, req_edge;
  logic          done_q;
  logic          wrap_w;
  logic          capture_w;

  always_comb begin
    phase_nx  = phase_q + PW'(slot_step(req_q));
    wrap_w    = tick_i && (phase_nx < phase_q);
    sample_o  = tick_i && (phase_q < MID) && (phase_nx >= MID);
    req_edge  = corr_for_slot(int'(phase_q), int'(MID));
    capture_w = edge_i && qual_i && (req_q == CORR_NONE) && !done_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      req_q   <= CORR_NONE;
      done_q  <= 1'b0;
    end else if (!en_i) begin
      phase_q <= '0;
      req_q   <= CORR_NONE;
      done_q  <= 1'b0;
    end else begin
      if (tick_i) phase_q <= phase_nx;
      if (capture_w)   req_q <= req_edge;
      else if (tick_i) req_q <= CORR_NONE;
      if (tick_i) begin
        if (wrap_w)                  done_q <= 1'b0;
        else if (req_q != CORR_NONE) done_q <= 1'b1;
      end
    end
  end

  assign phase_o = phase_q;

  // R3: free-running step of one slot per tick
  a_r3_free_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i && req_q == CORR_NONE) |=>
      (!en_i || phase_q == $past(phase_q) + PW'(1)));

  // R3: phase holds between ticks
  a_r3_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !tick_i) |=> (!en_i || $stable(phase_q)));

  // R5: no tick moves the phase by more than two slots
  a_r5_bounded_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && tick_i) |=> (!en_i || PW'(phase_q - $past(phase_q)) <= PW'(2)));

  // R6: after a correction in this bit no new request appears
  a_r6_one_per_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && done_q && req_q == CORR_NONE) |=> (req_q == CORR_NONE));

  // R7: unqualified edges raise no request
  a_r7_noise_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (!qual_i && req_q == CORR_NONE) |=> (req_q == CORR_NONE));

  // R9: powersave returns the loop to slot 0
  a_r9_phase_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (phase_q == '0 && req_q == CORR_NONE));

endmodule

// File: rtl/fwclk_recover.sv
module fwclk_recover #(
  parameter int unsigned BASE_DIV = 4,
  parameter int unsigned SLOTS    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_en,
  input  logic clk_fast_sel,
  input  logic rate_low_sel,
  input  logic rate_top_sel,
  input  logic carrier_in,
  input  logic rx_bit,
  output logic sync_out,
  output logic data_clocked,
  output logic data_raw,
  output logic carrier_out
);
  localparam int unsigned PW = $clog2(SLOTS);
  localparam logic [PW-1:0] MID = PW'(SLOTS / 2);

  logic          tick_w;
  logic          level_w;
  logic          edge_w;
  logic          sample_w;
  logic [PW-1:0] phase_w;
  logic          dq_q;

  fwclk_sync u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (rx_en),
    .d_i     (rx_bit),
    .level_o (level_w),
    .edge_o  (edge_w)
  );

  fwclk_slot_timer #(.BASE_DIV(BASE_DIV)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (rx_en),
    .fast_i    (clk_fast_sel),
    .sel_low_i (rate_low_sel),
    .sel_top_i (rate_top_sel),
    .tick_o    (tick_w)
  );

  fwclk_dpll #(.SLOTS(SLOTS)) u_dpll (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (rx_en),
    .tick_i   (tick_w),
    .edge_i   (edge_w),
    .qual_i   (carrier_in),
    .phase_o  (phase_w),
    .sample_o (sample_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dq_q <= 1'b0;
    else if (!rx_en)   dq_q <= 1'b0;
    else if (sample_w) dq_q <= level_w;
  end

  assign sync_out     = rx_en && (phase_w < MID);
  assign data_clocked = rx_en && dq_q;
  assign data_raw     = rx_bit;
  assign carrier_out  = rx_en && carrier_in;

  // R8: the latch only moves on a mid-bit sample
  a_r8_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && !sample_w) |=> $stable(dq_q));

  // R8: a sample lands as the sync square wave falls
  a_r8_sample_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && sample_w) |=> (!rx_en || !sync_out));

endmodule

// File: tb/test_fwclk_recover.sv
module test_fwclk_recover;
  localparam int BASE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b1;
  logic clk_fast_sel = 1'b0;
  logic rate_low_sel = 1'b1;
  logic rate_top_sel = 1'b0;
  logic carrier_in = 1'b0;
  logic rx_bit = 1'b0;
  logic sync_out, data_clocked, data_raw, carrier_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  fwclk_recover #(.BASE_DIV(BASE), .SLOTS(16)) i_fwclk_recover (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .clk_fast_sel(clk_fast_sel),
    .rate_low_sel(rate_low_sel), .rate_top_sel(rate_top_sel),
    .carrier_in(carrier_in), .rx_bit(rx_bit), .sync_out(sync_out),
    .data_clocked(data_clocked), .data_raw(data_raw), .carrier_out(carrier_out)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", what, act, exp, cyc);
    end
  endtask

  // bench's own rate table (R2)
  function automatic int slot_cycles(input bit f, input bit lo, input bit top);
    if (!f) return lo ? BASE : BASE / 2;
    if (lo) return BASE * 4;
    return top ? BASE : BASE * 2;
  endfunction

  // ---------------- behavioural reference model ----------------
  int m_s1, m_s2, m_s3, m_cnt, m_ph, m_req, m_done, m_dq;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !rx_en) begin
      m_s1 = 0; m_s2 = 0; m_s3 = 0; m_cnt = 0; m_ph = 0;
      m_req = 0; m_done = 0; m_dq = 0;
    end else begin
      int d, t, e, step, nph, nreq, ndone;
      d = slot_cycles(clk_fast_sel, rate_low_sel, rate_top_sel);
      t = (m_cnt >= d - 1);
      e = (m_s2 != m_s3) && carrier_in;
      step = (m_req == 1) ? 2 : (m_req == 2) ? 0 : 1;
      nph = (m_ph + step) % 16;
      nreq = m_req;
      if (e && m_req == 0 && m_done == 0)
        nreq = (m_ph == 0) ? 0 : (m_ph < 8) ? 2 : 1;
      else if (t) nreq = 0;
      ndone = m_done;
      if (t) begin
        if (nph < m_ph) ndone = 0;
        else if (m_req != 0) ndone = 1;
      end
      if (t && m_ph < 8 && nph >= 8) m_dq = m_s2;
      m_cnt = t ? 0 : m_cnt + 1;
      if (t) m_ph = nph;
      m_req = nreq; m_done = ndone;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = rx_bit;
    end
  end

  bit cmp_en = 0;
  always @(negedge clk) begin
    cyc++;
    if (cmp_en) begin
      check(sync_out == (rx_en && m_ph < 8), "R3 R4 R5 R6 R7 sync_out vs model",
            sync_out, rx_en && m_ph < 8);
      check(data_clocked == (rx_en && m_dq != 0), "R8 data_clocked vs model",
            data_clocked, rx_en && m_dq != 0);
      check(data_raw == rx_bit, "R1 data_raw", data_raw, rx_bit);
      check(carrier_out == (rx_en && carrier_in), "R9 carrier_out",
            carrier_out, rx_en && carrier_in);
      if (!rx_en) check(!sync_out && !data_clocked, "R9 powersave outputs",
                        {sync_out, data_clocked}, 0);
    end
  end

  // ---------------- lock checker (R10) ----------------
  int bit_idx = 0, bit_start = 0, bit_len = 64, cur_bit = 0, lock_hits = 0;
  bit lock_en = 0, prev_sync = 0;
  always @(negedge clk) begin
    if (lock_en && prev_sync && !sync_out && bit_idx >= 16) begin
      int off;
      off = cyc - bit_start;
      lock_hits++;
      check(off >= bit_len / 4 && off <= (3 * bit_len) / 4,
            "R10 sample position in bit", off, bit_len / 2);
      check(data_clocked == cur_bit, "R10 sampled value", data_clocked, cur_bit);
    end
    prev_sync = sync_out;
  end

  task automatic send_bit(input int v, input int len);
    @(negedge clk);
    rx_bit = v[0];
    bit_start = cyc; cur_bit = v; bit_len = len;
    repeat (len - 1) @(negedge clk);
  endtask

  task automatic preamble(input int nbits, input int len, input int skew);
    repeat (skew) @(negedge clk);
    bit_idx = 0; lock_hits = 0; lock_en = 1;
    for (int i = 0; i < nbits; i++) begin
      send_bit(i % 2 == 0 ? int'(!rx_bit) : int'(!rx_bit), len);
      bit_idx++;
    end
    lock_en = 0;
    check(lock_hits > 0, "R10 lock samples seen", lock_hits, 1);
  endtask

  task automatic measure_period(input int exp, input string tag);
    int t0;
    @(negedge clk); while (!(sync_out == 0)) @(negedge clk);
    while (!sync_out) @(negedge clk);
    t0 = cyc;
    @(negedge clk); while (sync_out) @(negedge clk);
    while (!sync_out) @(negedge clk);
    check(cyc - t0 == exp, tag, cyc - t0, exp);
  endtask

  task automatic set_rate(input bit f, input bit lo, input bit top);
    @(negedge clk);
    clk_fast_sel = f; rate_low_sel = lo; rate_top_sel = top;
  endtask

  // watchdog
  initial begin
    while (cyc < 190000 && !done) @(negedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sync_out == 1'b1, "R3 reset sync_out in slot 0", sync_out, 1);
    check(data_clocked == 1'b0, "R8 reset data_clocked", data_clocked, 0);
    @(negedge clk); rst_n = 1'b1; cmp_en = 1;

    // R2: sync period per rate, no edges, carrier low
    set_rate(0, 1, 0); measure_period(16 * 4,  "R2 slow clk low rate");
    set_rate(0, 0, 0); measure_period(16 * 2,  "R2 slow clk mid rate");
    set_rate(0, 0, 1); measure_period(16 * 2,  "R2 slow clk top sel ignored");
    set_rate(1, 1, 1); measure_period(16 * 16, "R2 fast clk low rate");
    set_rate(1, 0, 0); measure_period(16 * 8,  "R2 fast clk mid rate");
    set_rate(1, 0, 1); measure_period(16 * 4,  "R2 fast clk top rate");

    // R7: edges with carrier low leave the flywheel at nominal
    set_rate(0, 1, 0);
    fork
      for (int i = 0; i < 40; i++) begin @(negedge clk); rx_bit = ~rx_bit; repeat (22) @(negedge clk); end
      begin measure_period(64, "R7 period with unqualified edges");
            measure_period(64, "R7 period with unqualified edges"); end
    join

    // R10: lock at nominal and at off-nominal periods
    carrier_in = 1'b1;
    preamble(28, 64, 5);
    preamble(28, 62, 37);
    preamble(28, 66, 19);
    set_rate(1, 1, 0); preamble(24, 256, 101);
    set_rate(1, 0, 0); preamble(24, 128, 60);

    // R6: burst of edges inside one bit, model tracks the single correction
    set_rate(0, 1, 0);
    for (int i = 0; i < 6; i++) begin @(negedge clk); rx_bit = ~rx_bit; @(negedge clk); end
    repeat (200) @(negedge clk);

    // R9: powersave and restart from slot 0
    @(negedge clk); rx_en = 1'b0;
    repeat (3) @(negedge clk);
    check(sync_out == 0 && data_clocked == 0 && carrier_out == 0, "R9 powersave forced low",
          {sync_out, data_clocked, carrier_out}, 0);
    @(negedge clk); rx_en = 1'b1;
    #1 check(sync_out == 1'b1, "R9 restart in slot 0", sync_out, 1);
    rx_bit = 1'b1;
    repeat (300) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule